// File: doc/BRIEF.md
# Half-Bridge Swept-Frequency Gate Driver

This block produces the two complementary gate-drive signals for a resonant half-bridge from a digital period counter. Each switching period is divided at its midpoint. The low-side output is active in the first half and the high-side output in the second half. A dead interval at the start of each half keeps both outputs low across every switch-over.

The period is not fixed. The block always moves the period toward a target chosen by a mode input: preheat, ignition or run. A start period is loaded each time the oscillator is enabled. From there, the period approaches the target in geometric steps, with one step per completed period. This gives an exponential frequency sweep without a multiplier. Mode, dead time and slew rate are sampled only at period boundaries, so a pulse is never cut short.

The block also raises a one-clock strobe at the end of every low-side interval. A downstream current check can use this strobe as its sampling point. Dropping the enable input forces both outputs low in the same clock.

Top module: `hb_sweep_driver`

## Requirements
- R1: While reset is asserted and after its release, with the enable input low, both gate outputs and the strobe are 0 and the reported period equals MIN_PER (4).
- R2: On the first clock edge at which the enable input is high while the block is idle, counting starts at position 0 with the period set to the start-period input. A start period below MIN_PER is raised to MIN_PER.
- R3: Within a period P, let H = floor(P/2) and let D be the effective dead time. The low-side output is high at positions D to H-1 and the high-side output is high at positions H+D to P-1. The two outputs are never high together.
- R4: The effective dead time is the smaller of the dead-time input and H-1, where H is half of the period it applies to.
- R5: At the end of each period the next period is cur + ((target - cur) >>> k), using arithmetic shift by the slew-shift input k. If that step is zero while target > cur, the step is +1. The result is never below MIN_PER.
- R6: Target selection by the 2-bit mode input: 0 selects the preheat period, 1 the ignition period, and 2 or 3 the run period.
- R7: Mode, dead-time and slew-shift inputs take effect only at a period boundary or at start. A change in the middle of a period leaves the rest of that period unchanged.
- R8: When the enable input is low, both outputs and the strobe are 0 in that same clock. A later enable restarts the sequence as in R2.
- R9: The strobe is high for exactly one clock, at position H, which is the first clock after the low-side interval ends. It is raised only while running.
- R10: The period output shows the period currently being generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscEn | input | 1 | Oscillator enable; low on fault, lockout or shutdown |
| modeSel | input | 2 | Target select: 0 preheat, 1 ignition, 2/3 run |
| startPer | input | PW | Period loaded when oscillation starts, in clocks |
| preheatPer | input | PW | Preheat target period |
| ignitePer | input | PW | Ignition (minimum-frequency) target period |
| runPer | input | PW | Run target period |
| deadIn | input | DW | Requested dead time in clocks |
| slewShift | input | SW | Slew shift k; 0 jumps directly to the target |
| loGate | output | 1 | Low-side gate command |
| hiGate | output | 1 | High-side gate command |
| loFallStrobe | output | 1 | One-clock pulse as the low-side interval ends |
| periodNow | output | PW | Period currently in use |

## Verification
The bench uses the default build: PW=16, DW=8, SW=3, MIN_PER=4. With these values, periods from 4 to several dozen clocks and shifts from 0 to 3 can be checked clock by clock within a short run. The vectors cover rising and falling sweeps and an immediate jump with k=0. They include a dead-time request far above half the period, a start period below the floor, a target below the floor, and an odd period whose two halves differ by one clock. Directed tests change the mode and the dead time in the middle of a period, drop the enable inside a low-side interval, and restart with a new start period.

// File: rtl/hb_sweep_pkg.sv
package hb_sweep_pkg;

  typedef enum logic [1:0] {
    MODE_PREHEAT = 2'd0,
    MODE_IGNITE  = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_ALT = 2'd3
  } sweepMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;     // idle -> running this edge
    logic boundary;  // last position of the current period
  } sweepEv_t;

endpackage

// File: rtl/hb_sweep_path.sv
module hb_sweep_path
  import hb_sweep_pkg::*;
#(
  parameter int PW      = 16,
  parameter int DW      = 8,
  parameter int SW      = 3,
  parameter int MIN_PER = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  sweepEv_t      ev,
  input  logic [1:0]    modeSel,
  input  logic [PW-1:0] startPer,
  input  logic [PW-1:0] preheatPer,
  input  logic [PW-1:0] ignitePer,
  input  logic [PW-1:0] runPer,
  input  logic [DW-1:0] deadIn,
  input  logic [SW-1:0] slewShift,
  output logic [PW-1:0] curPer,
  output logic [DW-1:0] deadQ
);

  localparam logic [PW-1:0] MinP = PW'(MIN_PER);
  localparam int XW = PW + 2;

  function automatic logic [DW-1:0] clampDead(input logic [DW-1:0] d,
                                              input logic [PW-1:0] p);
    logic [PW-1:0] limit;
    logic [PW-1:0] dWide;
    limit = (p >> 1) - PW'(1);
    dWide = PW'(d);
    return (dWide > limit) ? limit[DW-1:0] : d;
  endfunction

  logic [PW-1:0] tgtSel;
  logic [PW-1:0] startClamp;
  logic [PW-1:0] nextPer;
  logic signed [XW-1:0] diffS, stepS, sumS;
  logic [PW-1:0] nextRaw;

  always_comb begin
    unique case (sweepMode_e'(modeSel))
      MODE_PREHEAT: tgtSel = preheatPer;
      MODE_IGNITE:  tgtSel = ignitePer;
      default:      tgtSel = runPer;
    endcase
  end

  always_comb begin
    diffS = $signed({2'b00, tgtSel}) - $signed({2'b00, curPer});
    stepS = diffS >>> slewShift;
    if (stepS == '0 && diffS != '0 && !diffS[XW-1])
      stepS = XW'(1);
    sumS    = $signed({2'b00, curPer}) + stepS;
    nextRaw = sumS[PW-1:0];
    nextPer = (nextRaw < MinP) ? MinP : nextRaw;
  end

  assign startClamp = (startPer < MinP) ? MinP : startPer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPer <= MinP;
      deadQ  <= '0;
    end else if (ev.start) begin
      curPer <= startClamp;
      deadQ  <= clampDead(deadIn, startClamp);
    end else if (ev.boundary) begin
      curPer <= nextPer;
      deadQ  <= clampDead(deadIn, nextPer);
    end
  end

  logic evAny;
  assign evAny = ev.start | ev.boundary;

  // R4
  dead_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    PW'(deadQ) <= ((curPer >> 1) - PW'(1)));

  // R5
  period_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    curPer >= MinP);

  // R7
  period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(curPer) || !$stable(deadQ)) |-> $past(evAny));

endmodule

// File: rtl/hb_sweep_ctrl.sv
module hb_sweep_ctrl
  import hb_sweep_pkg::*;
#(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscEn,
  input  logic [PW-1:0] curPer,
  input  logic [DW-1:0] deadQ,
  output sweepEv_t      ev,
  output logic          loGate,
  output logic          hiGate,
  output logic          loFallStrobe
);

  logic          running;
  logic [PW-1:0] cntQ;
  logic [PW-1:0] half;
  logic [PW-1:0] deadW;
  logic          active;

  assign half   = curPer >> 1;
  assign deadW  = PW'(deadQ);
  assign active = running & oscEn;

  assign ev.start    = oscEn & ~running;
  assign ev.boundary = active & (cntQ == curPer - PW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cntQ    <= '0;
    end else if (!oscEn) begin
      running <= 1'b0;
      cntQ    <= '0;
    end else if (ev.start) begin
      running <= 1'b1;
      cntQ    <= '0;
    end else if (ev.boundary) begin
      cntQ    <= '0;
    end else begin
      cntQ    <= cntQ + PW'(1);
    end
  end

  assign loGate       = active & (cntQ >= deadW) & (cntQ < half);
  assign hiGate       = active & (cntQ >= half + deadW);
  assign loFallStrobe = active & (cntQ == half);

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loGate && hiGate));

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!loGate && !hiGate && !loFallStrobe));

  // R9
  strobe_after_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    loFallStrobe |-> $past(loGate));

  // R9
  lo_fall_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(loGate) && oscEn && $past(oscEn)) |-> loFallStrobe);

endmodule

// File: rtl/hb_sweep_driver.sv
module hb_sweep_driver
  import hb_sweep_pkg::*;
#(
  parameter int PW      = 16,
  parameter int DW      = 8,
  parameter int SW      = 3,
  parameter int MIN_PER = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          oscEn,
  input  logic [1:0]    modeSel,
  input  logic [PW-1:0] startPer,
  input  logic [PW-1:0] preheatPer,
  input  logic [PW-1:0] ignitePer,
  input  logic [PW-1:0] runPer,
  input  logic [DW-1:0] deadIn,
  input  logic [SW-1:0] slewShift,
  output logic          loGate,
  output logic          hiGate,
  output logic          loFallStrobe,
  output logic [PW-1:0] periodNow
);

  sweepEv_t      ev;
  logic [PW-1:0] curPer;
  logic [DW-1:0] deadQ;

  hb_sweep_ctrl #(.PW(PW), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn),
    .curPer(curPer), .deadQ(deadQ), .ev(ev),
    .loGate(loGate), .hiGate(hiGate), .loFallStrobe(loFallStrobe)
  );

  hb_sweep_path #(.PW(PW), .DW(DW), .SW(SW), .MIN_PER(MIN_PER)) u_path (
    .clk(clk), .rstN(rstN), .ev(ev), .modeSel(modeSel),
    .startPer(startPer), .preheatPer(preheatPer), .ignitePer(ignitePer),
    .runPer(runPer), .deadIn(deadIn), .slewShift(slewShift),
    .curPer(curPer), .deadQ(deadQ)
  );

  assign periodNow = curPer;

endmodule

// File: tb/hb_sweep_driver_test.sv
module hb_sweep_driver_test;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int DW = 8;
  localparam int SW = 3;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] st;
    logic [15:0] pre;
    logic [15:0] ign;
    logic [15:0] run;
    logic [7:0]  dead;
    logic [2:0]  k;
  } vec_t;

  // mode, start, preheat, ignite, run, dead, k
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'd20, 16'd40, 16'd60, 16'd30, 8'd3,   3'd1},  // rising sweep to preheat
    '{2'd1, 16'd40, 16'd10, 16'd80, 16'd20, 8'd2,   3'd2},  // slow rise to ignition
    '{2'd2, 16'd64, 16'd12, 16'd90, 16'd32, 8'd5,   3'd0},  // immediate jump to run
    '{2'd0, 16'd10, 16'd3,  16'd50, 16'd50, 8'd200, 3'd0},  // dead clamp, floor on target
    '{2'd0, 16'd2,  16'd9,  16'd50, 16'd50, 8'd1,   3'd0},  // start floor, odd period
    '{2'd3, 16'd30, 16'd8,  16'd8,  16'd50, 8'd4,   3'd3}   // mode 3 picks run
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscEn = 1'b0;
  logic [1:0] modeSel = '0;
  logic [PW-1:0] startPer = '0, preheatPer = '0, ignitePer = '0, runPer = '0;
  logic [DW-1:0] deadIn = '0;
  logic [SW-1:0] slewShift = '0;
  logic loGate, hiGate, loFallStrobe;
  logic [PW-1:0] periodNow;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_sweep_driver uut (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .modeSel(modeSel),
    .startPer(startPer), .preheatPer(preheatPer), .ignitePer(ignitePer),
    .runPer(runPer), .deadIn(deadIn), .slewShift(slewShift),
    .loGate(loGate), .hiGate(hiGate), .loFallStrobe(loFallStrobe),
    .periodNow(periodNow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int floorMin(input int p);
    return (p < 4) ? 4 : p;
  endfunction

  function automatic int deadEff(input int d, input int p);
    int lim;
    lim = p / 2 - 1;
    return (d > lim) ? lim : d;
  endfunction

  function automatic int slewNext(input int cur, input int tgt, input int k);
    int diff, step;
    diff = tgt - cur;
    step = diff >>> k;
    if (step == 0 && diff > 0) step = 1;
    return floorMin(cur + step);
  endfunction

  function automatic int targetOf(input int mode, input vec_t v);
    if (mode == 0) return int'(v.pre);
    if (mode == 1) return int'(v.ign);
    return int'(v.run);
  endfunction

  // Walks one period, one sample per negedge; optional mid-period change.
  task automatic checkPeriod(input int p, input int d, input string req,
                             input int chgAt, input logic [1:0] chgMode,
                             input logic [DW-1:0] chgDead);
    int h, bad, firstPos, actBits, expBits;
    h = p / 2;
    bad = 0; firstPos = -1; actBits = 0; expBits = 0;
    for (int j = 0; j < p; j++) begin
      bit eLo, eHi, eSt;
      @(negedge clk);
      eLo = (j >= d) && (j < h);
      eHi = (j >= h + d);
      eSt = (j == h);
      if (loGate !== eLo || hiGate !== eHi || loFallStrobe !== eSt ||
          int'(periodNow) != p) begin
        if (bad == 0) begin
          firstPos = j;
          actBits = {loGate, hiGate, loFallStrobe};
          expBits = {eLo, eHi, eSt};
        end
        bad++;
      end
      if (j == chgAt) begin
        modeSel = chgMode;
        deadIn  = chgDead;
      end
    end
    check(bad == 0, req, $sformatf("period %0d dead %0d, first bad pos %0d lo/hi/strobe bits, period %0d",
          p, d, firstPos, int'(periodNow)), actBits, expBits);
  endtask

  task automatic stopAndCheck(input string req);
    oscEn = 1'b0;
    #1;
    check(!loGate && !hiGate && !loFallStrobe, req, "outputs when enable dropped",
          {loGate, hiGate, loFallStrobe}, 0);
    @(negedge clk);
    @(negedge clk);
    check(!loGate && !hiGate && !loFallStrobe, req, "outputs while disabled",
          {loGate, hiGate, loFallStrobe}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 1);
    check(!loGate && !hiGate && !loFallStrobe, "R1", "outputs in reset",
          {loGate, hiGate, loFallStrobe}, 0);
    check(periodNow == 16'd4, "R1", "period in reset", int'(periodNow), 4);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!loGate && !hiGate && !loFallStrobe && periodNow == 16'd4, "R1",
          "idle after reset", {loGate, hiGate, loFallStrobe, periodNow[3:0]}, 4);

    // table walk: R2 R3 R4 R5 R6 R9 R10
    for (int v = 0; v < NV; v++) begin
      int p, d, tgt;
      modeSel    = VECS[v].mode;
      startPer   = VECS[v].st;
      preheatPer = VECS[v].pre;
      ignitePer  = VECS[v].ign;
      runPer     = VECS[v].run;
      deadIn     = VECS[v].dead;
      slewShift  = VECS[v].k;
      oscEn      = 1'b1;
      tgt = targetOf(int'(VECS[v].mode), VECS[v]);
      p = floorMin(int'(VECS[v].st));
      for (int n = 0; n < 6; n++) begin
        d = deadEff(int'(VECS[v].dead), p);
        checkPeriod(p, d, $sformatf("R2 R3 R4 R5 R6 R9 R10 vec%0d", v), -1, 2'd0, 8'd0);
        p = slewNext(p, tgt, int'(VECS[v].k));
      end
      stopAndCheck("R8");
    end

    // R7: mode and dead-time change in mid-period act only at the boundary
    modeSel = 2'd0; startPer = 16'd24; preheatPer = 16'd24; ignitePer = 16'd40;
    runPer = 16'd60; deadIn = 8'd2; slewShift = 3'd0;
    oscEn = 1'b1;
    checkPeriod(24, 2, "R7 current period unchanged", 5, 2'd1, 8'd6);
    checkPeriod(40, 6, "R7 R6 new target and dead", -1, 2'd0, 8'd0);
    stopAndCheck("R8");

    // R8: enable dropped inside the low-side interval, then restart (R2)
    modeSel = 2'd0; startPer = 16'd16; preheatPer = 16'd16; deadIn = 8'd2;
    oscEn = 1'b1;
    for (int j = 0; j < 5; j++) @(negedge clk);
    check(loGate == 1'b1, "R3", "low side active at position 4", int'(loGate), 1);
    stopAndCheck("R8");
    startPer = 16'd12; preheatPer = 16'd12;
    oscEn = 1'b1;
    checkPeriod(12, 2, "R8 R2 restart from start period", -1, 2'd0, 8'd2);
    stopAndCheck("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule